// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block receives configuration words for a tuning synthesizer over three wires: a bus clock, a data line and an enable line. The lines arrive already synchronous to the system clock. Each bus line is registered once, and edges are found by comparing the live value with the registered one. While enable is high, every rising bus-clock edge shifts one data bit into a 16-bit shift register, most significant bit first. When enable falls, a frame that carried exactly sixteen bits is committed. Its first bit picks the destination. A 0 sends the other fifteen bits to the frequency latch, and a 1 sends them to the control latch. A one-cycle strobe marks each commit.

The control word is laid out, from bit 14 down to bit 0, as follows:

| Bits | Field |
|------|-------|
| 14 | band |
| 13 | reference select |
| 12:9 | charge-pump gain |
| 8 | low-field gate |
| 7 | synchronous load |
| 6:5 | phase-detector mode |
| 4 | bus power save |
| 3:0 | test select T3..T0 |

When the gate bit is 0, bits 7..0 are stored as zero. The test-select bits drive one multiplexed test output.

After reset the receiver is cold. A train of ten bus-clock pulses with enable low marks it primed. A committed control word marks it both primed and ready. Frequency words are accepted only once it is ready.

Top module: `tri_wire_rx`

## Requirements
- R1: While bus_en is high, each rising edge of bus_clk shifts bus_data into the shift register. The first bit sent ends up as the select bit, and the next fifteen bits form the payload, most significant bit first.
- R2: A commit happens in the cycle after bus_en falls, and only when exactly 16 rising bus_clk edges occurred while enable was high. A frame with more or fewer edges leaves both latches and the strobes unchanged.
- R3: A committed frame with select bit 1 loads ctrl_word and pulses word_b_stb for one cycle. A committed frame with select bit 0 loads freq_word and pulses word_a_stb. The two strobes are never high together.
- R4: When payload bit 8 of a control frame is 0, ctrl_word[7:0] is stored as zero whatever was sent.
- R5: rx_primed rises after 10 rising bus_clk edges with bus_en low, counted since the last enable window. Nine such edges are not enough.
- R6: Frequency frames are ignored until a control frame has been accepted. rx_ready then rises and stays high until reset.
- R7: test_out follows ctrl_word[3:0] as follows. 0000 gives constant 1, 0100 gives ref_tap, 0001 gives div_tap, and 0101 gives lock_tap. Any other code gives 0.
- R8: If ctrl_word bit 4 (after any update from the frame) is 1 when enable falls, rx_awake drops to 0. A rising bus_en sets rx_awake back to 1 in the next cycle.
- R9: After reset, freq_word and ctrl_word are 0, rx_ready and rx_primed are 0, rx_awake is 1 and test_out is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_clk | input | 1 | serial bus clock |
| bus_data | input | 1 | serial bus data |
| bus_en | input | 1 | serial frame enable, active high |
| ref_tap | input | 1 | reference signal routed to the test output |
| div_tap | input | 1 | divider output routed to the test output |
| lock_tap | input | 1 | lock flag routed to the test output |
| freq_word | output | 15 | frequency latch |
| ctrl_word | output | 15 | control latch |
| word_a_stb | output | 1 | frequency latch updated |
| word_b_stb | output | 1 | control latch updated |
| rx_primed | output | 1 | clock-train or control-word initialization seen |
| rx_ready | output | 1 | frequency words are accepted |
| rx_awake | output | 1 | bus receiver powered |
| test_out | output | 1 | selected test signal |

## Verification
A wrong bit count, a wrong select decode or a wrong shift direction shows at the ports one cycle after enable falls. It appears as a missing, extra or corrupted strobe and latch value, which the scoreboard compares against the word the driver sent. A fault in the initialization state shows as a frequency frame that is taken too early or never taken. A primed flag that rises on the wrong pulse shows right after the ninth or tenth idle pulse. A wrong mask or test decode shows in the latched control value or in test_out as soon as the next control word has been committed.

// File: rtl/tri_wire_rx.sv
module tri_wire_rx #(
  parameter int SR_W        = 16,
  parameter int INIT_PULSES = 10,
  parameter int GATE_BIT    = 8,
  parameter int PWR_BIT     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_clk,
  input  logic            bus_data,
  input  logic            bus_en,
  input  logic            ref_tap,
  input  logic            div_tap,
  input  logic            lock_tap,
  output logic [SR_W-2:0] freq_word,
  output logic [SR_W-2:0] ctrl_word,
  output logic            word_a_stb,
  output logic            word_b_stb,
  output logic            rx_primed,
  output logic            rx_ready,
  output logic            rx_awake,
  output logic            test_out
);

  localparam int PAY_W  = SR_W - 1;
  localparam int CNT_W  = $clog2(SR_W + 2);
  localparam int IDLE_W = $clog2(INIT_PULSES + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(SR_W);
  localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(SR_W + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(INIT_PULSES - 1);
  localparam logic [IDLE_W-1:0] IDLE_SAT  = IDLE_W'(INIT_PULSES);

  logic              bclk_q, ben_q;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [PAY_W-1:0]  ctrl_next;

  logic clk_rise, shift_en, idle_tick, en_rise, en_fall, frame_ok, a_take, b_take, save_after;

  assign clk_rise  = bus_clk & ~bclk_q;
  assign shift_en  = clk_rise & bus_en;
  assign idle_tick = clk_rise & ~bus_en;
  assign en_rise   = bus_en & ~ben_q;
  assign en_fall   = ben_q & ~bus_en;
  assign frame_ok  = en_fall && (bit_cnt == CNT_FULL);
  assign b_take    = frame_ok & sr[SR_W-1];
  assign a_take    = frame_ok & ~sr[SR_W-1] & rx_ready;

  always_comb begin
    ctrl_next = sr[PAY_W-1:0];
    if (!ctrl_next[GATE_BIT]) ctrl_next[GATE_BIT-1:0] = '0;
  end

  assign save_after = b_take ? ctrl_next[PWR_BIT] : ctrl_word[PWR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      ben_q  <= 1'b0;
    end else begin
      bclk_q <= bus_clk;
      ben_q  <= bus_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      sr <= {sr[SR_W-2:0], bus_data};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      rx_primed <= 1'b0;
    end else begin
      if (en_rise) idle_cnt <= '0;
      else if (idle_tick && idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
      if (b_take || (idle_tick && idle_cnt == IDLE_LAST)) rx_primed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word  <= '0;
      ctrl_word  <= '0;
      word_a_stb <= 1'b0;
      word_b_stb <= 1'b0;
      rx_ready   <= 1'b0;
      rx_awake   <= 1'b1;
    end else begin
      word_a_stb <= a_take;
      word_b_stb <= b_take;
      if (a_take) freq_word <= sr[PAY_W-1:0];
      if (b_take) begin
        ctrl_word <= ctrl_next;
        rx_ready  <= 1'b1;
      end
      if (en_rise) rx_awake <= 1'b1;
      else if (en_fall && save_after) rx_awake <= 1'b0;
    end
  end

  always_comb begin
    case (ctrl_word[3:0])
      4'b0000: test_out = 1'b1;
      4'b0100: test_out = ref_tap;
      4'b0001: test_out = div_tap;
      4'b0101: test_out = lock_tap;
      default: test_out = 1'b0;
    endcase
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_a_stb && word_b_stb)); // R3
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_a_stb |-> $stable(freq_word)); // R2
  AST_CTRL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[GATE_BIT] |-> (ctrl_word[GATE_BIT-1:0] == '0)); // R4
  AST_A_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    word_a_stb |-> rx_ready); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> rx_ready); // R6
  AST_B_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    word_b_stb |-> (rx_ready && rx_primed)); // R6
  AST_WAKE_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |=> rx_awake); // R8

endmodule

// File: tb/tri_wire_rx_tb.sv
module tri_wire_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_clk = 0, bus_data = 0, bus_en = 0;
  logic ref_tap = 0, div_tap = 0, lock_tap = 0;
  logic [14:0] freq_word, ctrl_word;
  logic word_a_stb, word_b_stb, rx_primed, rx_ready, rx_awake, test_out;

  tri_wire_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data), .bus_en(bus_en),
    .ref_tap(ref_tap), .div_tap(div_tap), .lock_tap(lock_tap),
    .freq_word(freq_word), .ctrl_word(ctrl_word), .word_a_stb(word_a_stb),
    .word_b_stb(word_b_stb), .rx_primed(rx_primed), .rx_ready(rx_ready),
    .rx_awake(rx_awake), .test_out(test_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] sb[$];

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic logic [14:0] mask_b(input logic [14:0] v);
    mask_b = v;
    if (!v[8]) mask_b[7:0] = '0;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [16:0] w, input int n);
    bus_en = 1; wt(3);
    for (int i = n - 1; i >= 0; i--) begin
      bus_data = w[i]; wt(2);
      bus_clk = 1; wt(3);
      bus_clk = 0; wt(2);
    end
    wt(2); bus_en = 0; wt(4);
  endtask

  task automatic word_a(input logic [14:0] v, input bit take);
    if (take) sb.push_back({1'b0, v});
    send({2'b00, v}, 16);
  endtask

  task automatic word_b(input logic [14:0] v);
    sb.push_back({1'b1, mask_b(v)});
    send({2'b01, v}, 16);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bus_clk = 1; wt(3);
      bus_clk = 0; wt(3);
    end
  endtask

  // monitor: R1 R3 scoreboard
  always @(negedge clk) begin
    if (rst_n && (word_a_stb || word_b_stb)) begin
      if (sb.size() == 0) chk(0, "R2 unexpected strobe", {word_b_stb, word_a_stb}, 0);
      else begin
        logic [15:0] e;
        e = sb.pop_front();
        chk(word_b_stb == e[15] && word_a_stb != e[15], "R3 target latch", word_b_stb, e[15]);
        if (e[15]) chk(ctrl_word == e[14:0], "R1 ctrl value", ctrl_word, e[14:0]);
        else       chk(freq_word == e[14:0], "R1 freq value", freq_word, e[14:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wt(3); rst_n = 1; wt(2);
    chk(freq_word == 0 && ctrl_word == 0, "R9 latches", {freq_word, ctrl_word}, 0);
    chk(!rx_ready && !rx_primed, "R9 flags", {rx_ready, rx_primed}, 0);
    chk(rx_awake && test_out, "R9 awake/test", {rx_awake, test_out}, 3);

    word_a(15'h1234, 0);
    chk(freq_word == 0 && !rx_ready, "R6 cold A ignored", freq_word, 0);

    pulses(9);
    chk(!rx_primed, "R5 nine pulses", rx_primed, 0);
    pulses(1);
    chk(rx_primed, "R5 ten pulses", rx_primed, 1);

    word_a(15'h1234, 0);
    chk(freq_word == 0 && !rx_ready, "R6 primed A ignored", freq_word, 0);

    word_b(15'h55C0);
    chk(rx_ready, "R6 ready after B", rx_ready, 1);
    chk(test_out, "R7 code 0000", test_out, 1);

    word_a(15'h5A3C, 1);
    word_a(15'h7FFF, 1);
    word_a(15'h0000, 1);
    word_a(15'h2B61, 1);

    send(17'h02AAA, 15);
    chk(freq_word == 15'h2B61, "R2 short frame", freq_word, 15'h2B61);
    send(17'h0ABCD, 17);
    chk(freq_word == 15'h2B61, "R2 long frame", freq_word, 15'h2B61);
    chk(ctrl_word == 15'h55C0, "R2 ctrl kept", ctrl_word, 15'h55C0);

    word_b(15'h7EFF);
    chk(ctrl_word[7:0] == 0, "R4 low bits zero", ctrl_word[7:0], 0);
    chk(test_out, "R4 test bits cleared", test_out, 1);

    word_b(15'h0104);
    ref_tap = 1; #1;
    chk(test_out, "R7 ref high", test_out, 1);
    ref_tap = 0; #1;
    chk(!test_out, "R7 ref low", test_out, 0);
    word_b(15'h0101);
    div_tap = 1; #1;
    chk(test_out, "R7 div", test_out, 1);
    word_b(15'h0105);
    chk(!test_out, "R7 lock low", test_out, 0);
    lock_tap = 1; #1;
    chk(test_out, "R7 lock high", test_out, 1);
    ref_tap = 1; #1;
    word_b(15'h0108);
    chk(!test_out, "R7 illegal code", test_out, 0);

    word_b(15'h0110);
    chk(!rx_awake, "R8 sleep after frame", rx_awake, 0);
    bus_en = 1; wt(2);
    chk(rx_awake, "R8 wake on enable", rx_awake, 1);
    bus_en = 0; wt(4);
    chk(!rx_awake, "R8 sleep again", rx_awake, 0);
    word_b(15'h0100);
    chk(rx_awake, "R8 stays awake", rx_awake, 1);

    wt(4);
    chk(sb.size() == 0, "R3 all commits seen", sb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule